// File: doc/BRIEF.md
# Incremental Sigma-Delta Decimation Filter

This block is the digital back end of a column-level incremental ADC built around a single-loop, second-order, one-bit sigma-delta modulator. A start pulse opens a conversion window of a fixed number of clock cycles, 255 by default. During the window the block takes one modulator bit per clock and feeds it through two cascaded integrating stages. The first stage is a counter and the second stage is an adder. When the window closes, the block latches the second-stage sum as a 15-bit result and raises a single-cycle done flag.

Both stages are cleared at every start. Each conversion therefore depends only on its own bits, which is what makes the operation incremental rather than free-running. The weighting that results is simple. Sample j of N (numbered from 1) adds N-j+1 to the result. Early samples weigh most, and a full window of ones gives N(N+1)/2 = 32640. That value fits 15 bits without wrapping.

Top module: `isd_decimator`

## Requirements
- R1: During a conversion, the input bit is sampled on each of the 255 rising edges that follow the edge at which start was sampled. The final result equals the sum over j = 1..255 of b_j*(256-j), where b_j is the j-th sampled bit. This is the value given by a first stage that counts ones and a second stage that adds the updated count on every cycle.
- R2: done is high in the cycle that follows the 255th sampling edge, and at no other point of the window.
- R3: A start pulse clears both stages. A start pulse during a running conversion aborts it without any done pulse, and the new conversion runs a full 255 samples with no trace of the aborted one.
- R4: done lasts exactly one cycle. result keeps its value until the next conversion completes.
- R5: An all-zero window yields 0. An all-one window yields 32640, and no stage wraps.
- R6: After reset, done is 0, result is 0 and the block is idle.
- R7: The input bit is ignored while no conversion is running. Bits applied between conversions do not change result or the outcome of the next conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts or restarts a conversion, sampled at the rising edge |
| mod_bit | input | 1 | Modulator output bit, one per clock |
| result | output | 15 | Latched conversion result |
| done | output | 1 | One-cycle pulse when a new result is latched |

## Verification
The assertions assume that start is a clean synchronous pulse and that mod_bit is a defined 0 or 1 at each sampling edge. They make no assumption about the bit pattern. Within those assumptions, the no-wrap and clear properties hold for every possible stream. The bench changes start and mod_bit only on falling clock edges and holds start high for exactly one cycle. It feeds bit streams from a behavioural second-order modulator with its integrators reset per conversion, from fixed patterns, and from isolated single-one streams, and it compares each result with a weighted sum computed in the bench.

// File: rtl/isd_pkg.sv
package isd_pkg;

  // Default conversion window length in modulator clocks.
  localparam int unsigned DEF_WINDOW = 255;
  // Default width of the latched result.
  localparam int unsigned DEF_OUT_W  = 15;

  // Largest value the cascade can reach: every sample a one.
  // Stage one ends at n, stage two at 1+2+...+n.
  function automatic longint unsigned full_scale(input int unsigned n);
    longint unsigned acc;
    acc = 0;
    for (int unsigned k = 1; k <= n; k++) acc += k;
    return acc;
  endfunction

  // Bits needed to hold values 0..v.
  function automatic int unsigned bits_for(input longint unsigned v);
    int unsigned w;
    w = 1;
    while ((longint'(1) << w) <= v) w++;
    return w;
  endfunction

endpackage

// File: rtl/isd_window_ctl.sv
module isd_window_ctl #(
  parameter int unsigned WINDOW = isd_pkg::DEF_WINDOW,
  localparam int unsigned CNT_W = (WINDOW > 1) ? $clog2(WINDOW) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic sample_en,
  output logic last_sample
);

  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WINDOW - 1);

  logic             busy_q;
  logic [CNT_W-1:0] idx_q;

  // A start takes priority: the edge that samples start never samples a bit.
  assign sample_en   = busy_q && !start;
  assign last_sample = sample_en && (idx_q == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
    end else if (busy_q) begin
      idx_q <= idx_q + 1'b1;
      if (idx_q == LAST_IDX) busy_q <= 1'b0;
    end
  end

  // R2: the index never leaves the window while running.
  p_idx_in_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (idx_q <= LAST_IDX));

  // R2: a running window is not left before its final sample.
  p_window_stays_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !start && idx_q != LAST_IDX) |=> busy_q);

  // R3: start always (re)opens a window at index zero.
  p_start_opens_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy_q && idx_q == '0));

endmodule

// File: rtl/isd_accum.sv
module isd_accum #(
  parameter int unsigned W = isd_pkg::DEF_OUT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] add_in,
  output logic [W-1:0] sum_q,
  output logic [W-1:0] sum_nxt,
  output logic         carry
);

  logic [W:0] wide;

  assign wide    = {1'b0, sum_q} + {1'b0, add_in};
  assign sum_nxt = wide[W-1:0];
  assign carry   = wide[W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sum_q <= '0;
    else if (clr)    sum_q <= '0;
    else if (en)     sum_q <= sum_nxt;
  end

  // R5: an enabled update never wraps past the stage width.
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr) |-> !carry);

  // R3: a clear leaves nothing behind from the previous conversion.
  p_cleared_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (sum_q == '0));

  // R7: a stage holds while it is neither enabled nor cleared.
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(sum_q));

endmodule

// File: rtl/isd_decimator.sv
module isd_decimator #(
  parameter int unsigned WINDOW = isd_pkg::DEF_WINDOW,
  parameter int unsigned OUT_W  = isd_pkg::DEF_OUT_W,
  parameter int unsigned ORDER  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mod_bit,
  output logic [OUT_W-1:0] result,
  output logic             done
);

  localparam longint unsigned FULL = isd_pkg::full_scale(WINDOW);

  initial begin
    if (isd_pkg::bits_for(FULL) > OUT_W)
      $error("result width too small for window");
  end

  logic sample_en;
  logic last_sample;

  isd_window_ctl #(.WINDOW(WINDOW)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .sample_en  (sample_en),
    .last_sample(last_sample)
  );

  // Cascade of integrating stages; stage 0 counts ones, each later
  // stage adds its predecessor's updated value every sampled cycle.
  logic [OUT_W-1:0] stage_in  [ORDER];
  logic [OUT_W-1:0] stage_q   [ORDER];
  logic [OUT_W-1:0] stage_nxt [ORDER];
  logic             stage_cy  [ORDER];

  genvar gi;
  generate
    for (gi = 0; gi < ORDER; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        assign stage_in[gi] = {{(OUT_W-1){1'b0}}, mod_bit};
      end else begin : g_chain
        assign stage_in[gi] = stage_nxt[gi-1];
      end
      isd_accum #(.W(OUT_W)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (start),
        .en     (sample_en),
        .add_in (stage_in[gi]),
        .sum_q  (stage_q[gi]),
        .sum_nxt(stage_nxt[gi]),
        .carry  (stage_cy[gi])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= last_sample;
      if (last_sample) result <= stage_nxt[ORDER-1];
    end
  end

  // R4: the completion flag is a single-cycle pulse.
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4: the result only moves on the edge that raises done.
  p_result_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

  // R5: a latched result never exceeds full scale.
  p_full_scale_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (64'(result) <= FULL));

  // R1: the counting stage never exceeds the number of samples taken.
  p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    64'(stage_q[0]) <= 64'(WINDOW));

  // R3: an aborting start suppresses the pending completion.
  p_abort_no_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done);

endmodule

// File: tb/isd_decimator_tb.sv
module isd_decimator_tb;

  localparam int N     = 255;
  localparam int OUT_W = 15;
  localparam int FULL  = N * (N + 1) / 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic             mod_bit = 1'b0;
  logic [OUT_W-1:0] result;
  logic             done;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic pat [1:N];

  always #5 clk = ~clk;

  isd_decimator u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mod_bit(mod_bit),
    .result(result), .done(done)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Weighted reference: bit j counts (N-j+1) times.
  function automatic int weighted(input int dummy);
    int s = 0;
    for (int j = 1; j <= N; j++) if (pat[j]) s += N - j + 1;
    return s + dummy;
  endfunction

  // Runs one conversion on pat[], checks done timing and the result.
  task automatic convert(input string req);
    int early_done = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int j = 1; j <= N; j++) begin
      mod_bit = pat[j];
      if (done) early_done++;
      @(negedge clk);
    end
    mod_bit = 1'b0;
    check({req, " R2 done at window end"}, done, 1);
    check({req, " R2 no early done"}, early_done, 0);
    check({req, " R1 result"}, result, weighted(0));
    @(negedge clk);
    check({req, " R4 done one cycle"}, done, 0);
  endtask

  // Behavioural second-order single-bit modulator, reset per conversion.
  task automatic modulate(input int u);
    int q = 1024, i1 = 0, i2 = 0, fb = -1024;
    for (int j = 1; j <= N; j++) begin
      i1 += u - fb;
      i2 += i1 - fb;
      pat[j] = (i2 >= 0);
      fb = pat[j] ? q : -q;
    end
  endtask

  initial begin
    while (cycles < 200000) begin
      @(posedge clk);
      cycles++;
    end
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int held;
    repeat (3) @(negedge clk);
    check("R6 reset done", done, 0);
    check("R6 reset result", result, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R7: idle input has no effect on outputs.
    mod_bit = 1'b1;
    repeat (20) @(negedge clk);
    check("R7 idle done", done, 0);
    check("R7 idle result", result, 0);
    mod_bit = 1'b0;

    for (int j = 1; j <= N; j++) pat[j] = 1'b0;
    convert("R5 zeros");
    check("R5 all zero", result, 0);
    for (int j = 1; j <= N; j++) pat[j] = 1'b1;
    convert("R5 ones");
    check("R5 all one full scale", result, FULL);

    // R1: isolated ones at chosen positions expose each bit's weight.
    for (int p = 1; p <= N; p += 23) begin
      for (int j = 1; j <= N; j++) pat[j] = (j == p);
      convert("R1 single one");
      check("R1 single weight", result, N - p + 1);
    end
    for (int j = 1; j <= N; j++) pat[j] = (j == N);
    convert("R1 last one");
    check("R1 last weight", result, 1);
    for (int j = 1; j <= N; j++) pat[j] = j[0];
    convert("R1 alternating");

    // R4: result holds while idle; R7: idle bits don't leak into next run.
    held = result;
    mod_bit = 1'b1;
    repeat (30) @(negedge clk);
    check("R4 result hold", result, held);
    check("R7 idle no done", done, 0);
    mod_bit = 1'b0;

    // R3: abort a run of ones midway, then convert zeros.
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0; mod_bit = 1'b1;
    repeat (100) @(negedge clk);
    check("R3 no done during abort", done, 0);
    for (int j = 1; j <= N; j++) pat[j] = 1'b0;
    convert("R3 after abort");
    check("R3 cleared by restart", result, 0);

    // Modulator sweep over DC levels.
    for (int u = -960; u <= 960; u += 120) begin
      modulate(u);
      convert("R1 modulator sweep");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule